// File: doc/BRIEF.md
# Strict-Sense Non-Blocking Three-Stage Fabric Path Controller

This block is the central set-up controller for a three-stage switching fabric with full interstage connection. The fabric has `R1` first-stage matrices with `N_IN` inlets each, `R2` middle matrices and `R3` last-stage matrices with `M_OUT` outlets each. Each outer matrix has exactly one link to every middle matrix. The controller keeps a busy bit for every interstage link, plus one record per inlet that holds the outlet and middle index of the call on that inlet. The crossbars that carry the data are outside this block.

A connect request names a global inlet and a global outlet. Inlet `i` sits on first-stage matrix `i / N_IN`, and outlet `o` sits on last-stage matrix `o / M_OUT`. The controller picks the lowest-numbered middle matrix whose link from the source matrix is idle and whose link to the destination matrix is idle. It marks both links busy and returns the chosen index. A release request names an inlet and frees both links of the call on it. A call that is set up is never moved. With `R2` at least `N_IN + M_OUT - 1`, which is the default, a connect between two idle ports always finds a middle matrix.

Requests use a valid/ready handshake and are accepted at most one per cycle. Each accepted request gets exactly one registered response in the next cycle. The response carries a status code and a middle index.

Top module: `clos_conn_ctrl`

## Requirements
- R1: While `rst` is high, `req_ready` and `rsp_valid` are low. `req_ready` is high from the first cycle after `rst` falls. After reset, every inlet, outlet and interstage link is idle, so a release of any inlet returns status 3.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_op` selects the request type: 0 is connect, 1 is release. Exactly one cycle after acceptance, `rsp_valid` is high for one cycle; in any other cycle it is low. A connect between an idle in-range inlet and an idle outlet returns status 0.
- R3: A successful connect reports on `rsp_mid` the lowest middle index `k` for which two conditions hold: link `k` of first-stage matrix `inlet / N_IN` is idle, and link `k` of last-stage matrix `outlet / M_OUT` is idle. Both of those links then become busy before the next request is evaluated, even for back-to-back requests.
- R4: A connect whose inlet already carries a call returns status 1 with `rsp_mid` 0. The link map and the call records are unchanged.
- R5: A connect whose outlet already carries a call, on an idle inlet, returns status 2 with `rsp_mid` 0. Nothing is changed.
- R6: A release of an inlet that carries a call returns status 0, with `rsp_mid` equal to the middle index of that call. It frees the inlet, its outlet and both links, so a later connect can reuse them.
- R7: A release of an idle inlet returns status 3 with `rsp_mid` 0. Nothing is changed.
- R8: A request is out of range if its inlet is not below `N_IN*R1`, or if it is a connect whose outlet is not below `M_OUT*R3`. Such a request returns status 4 with `rsp_mid` 0. Nothing is changed.
- R9: With `R2 >= N_IN + M_OUT - 1`, a connect between an idle inlet and an idle outlet never returns status 5. Status 5 means that no middle matrix qualifies.
- R10: A connect never changes the middle index of an established call. The release of a call reports the index that was chosen when the call was set up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_op | input | 1 | 0 = connect, 1 = release |
| req_inlet | input | IW = clog2(N_IN*R1) | Global inlet index |
| req_outlet | input | OW = clog2(M_OUT*R3) | Global outlet index (connect only) |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 3 | 0 ok, 1 inlet busy, 2 outlet busy, 3 inlet idle, 4 out of range, 5 blocked |
| rsp_mid | output | MW = clog2(R2) | Middle matrix chosen or freed; 0 on error |

## Verification
The bench builds the controller with `N_IN` = 2, `M_OUT` = 3 and `R1` = `R3` = 3, so `R2` defaults to 4, the smallest value the rule allows. With these values the inlet and outlet index fields have unused codes, so out-of-range requests can be exercised. A directed sequence drives one first-stage matrix and one last-stage matrix into the worst case: the source matrix holds one middle matrix and the destination matrix holds two different ones. The next connect must then take middle index 3, the last one. Random connect and release traffic on this minimum-size fabric then shows that the lowest-index choice never blocks.

// File: rtl/clos_pkg.sv
package clos_pkg;

    typedef enum logic [2:0] {
        ST_OK       = 3'd0,
        ST_IN_BUSY  = 3'd1,
        ST_OUT_BUSY = 3'd2,
        ST_IN_IDLE  = 3'd3,
        ST_RANGE    = 3'd4,
        ST_BLOCKED  = 3'd5
    } status_e;

    localparam logic OP_CONNECT = 1'b0;
    localparam logic OP_RELEASE = 1'b1;

endpackage

// File: rtl/clos_link_map.sv
// Busy bits for the interstage links of one side of the fabric:
// one row per outer matrix, one column per middle matrix.
module clos_link_map #(
    parameter int ROWS = 2,
    parameter int COLS = 3,
    parameter int RW   = 1,
    parameter int CW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic            clr_en,
    input  logic [RW-1:0]   row,
    input  logic [CW-1:0]   col,
    output logic [COLS-1:0] rd_bits
);

    logic [COLS-1:0] busy_d [ROWS];
    logic [COLS-1:0] busy_q [ROWS];

    always_comb begin
        busy_d = busy_q;
        if (set_en) begin
            busy_d[row][col] = 1'b1;
        end
        if (clr_en) begin
            busy_d[row][col] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++) begin
                busy_q[r] <= '0;
            end
        end else begin
            busy_q <= busy_d;
        end
    end

    assign rd_bits = busy_q[row];

endmodule

// File: rtl/clos_mid_pick.sv
// Lowest-index middle matrix whose two links are both idle.
module clos_mid_pick #(
    parameter int R2 = 3,
    parameter int MW = 2
) (
    input  logic [R2-1:0] a_busy,
    input  logic [R2-1:0] c_busy,
    output logic          found,
    output logic [MW-1:0] mid
);

    logic [R2-1:0] both_free;

    generate
        for (genvar g = 0; g < R2; g++) begin : g_free
            assign both_free[g] = !a_busy[g] && !c_busy[g];
        end
    endgenerate

    always_comb begin
        found = 1'b0;
        mid   = '0;
        for (int k = R2 - 1; k >= 0; k--) begin
            if (both_free[k]) begin
                found = 1'b1;
                mid   = MW'(k);
            end
        end
    end

endmodule

// File: rtl/clos_call_table.sv
// One record per inlet (live flag, outlet, middle index) plus a busy flag per outlet.
module clos_call_table #(
    parameter int NIN  = 4,
    parameter int NOUT = 4,
    parameter int IW   = 2,
    parameter int OW   = 2,
    parameter int MW   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          clr_en,
    input  logic [IW-1:0] inlet,
    input  logic [OW-1:0] outlet,
    input  logic [MW-1:0] mid,
    output logic          ent_live,
    output logic [OW-1:0] ent_outlet,
    output logic [MW-1:0] ent_mid,
    output logic          outlet_busy
);

    typedef struct packed {
        logic          live;
        logic [OW-1:0] outlet;
        logic [MW-1:0] mid;
    } entry_t;

    entry_t        ent_d   [NIN];
    entry_t        ent_q   [NIN];
    logic [NOUT-1:0] obusy_d;
    logic [NOUT-1:0] obusy_q;

    always_comb begin
        ent_d   = ent_q;
        obusy_d = obusy_q;
        if (wr_en) begin
            ent_d[inlet].live   = 1'b1;
            ent_d[inlet].outlet = outlet;
            ent_d[inlet].mid    = mid;
            obusy_d[outlet]     = 1'b1;
        end
        if (clr_en) begin
            ent_d[inlet].live               = 1'b0;
            obusy_d[ent_q[inlet].outlet]    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NIN; i++) begin
                ent_q[i] <= '0;
            end
            obusy_q <= '0;
        end else begin
            ent_q   <= ent_d;
            obusy_q <= obusy_d;
        end
    end

    assign ent_live    = ent_q[inlet].live;
    assign ent_outlet  = ent_q[inlet].outlet;
    assign ent_mid     = ent_q[inlet].mid;
    assign outlet_busy = obusy_q[outlet];

endmodule

// File: rtl/clos_conn_ctrl.sv
module clos_conn_ctrl
    import clos_pkg::*;
#(
    parameter int  N_IN    = 2,
    parameter int  M_OUT   = 2,
    parameter int  R1      = 2,
    parameter int  R3      = 2,
    parameter int  R2      = N_IN + M_OUT - 1,
    localparam int NIN_TOT  = N_IN * R1,
    localparam int NOUT_TOT = M_OUT * R3,
    localparam int IW = (NIN_TOT  > 1) ? $clog2(NIN_TOT)  : 1,
    localparam int OW = (NOUT_TOT > 1) ? $clog2(NOUT_TOT) : 1,
    localparam int MW = (R2 > 1) ? $clog2(R2) : 1,
    localparam int AW = (R1 > 1) ? $clog2(R1) : 1,
    localparam int CW = (R3 > 1) ? $clog2(R3) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [IW-1:0] req_inlet,
    input  logic [OW-1:0] req_outlet,
    output logic          rsp_valid,
    output logic [2:0]    rsp_status,
    output logic [MW-1:0] rsp_mid
);

    typedef struct packed {
        logic          ready;
        logic          rsp_valid;
        status_e       status;
        logic [MW-1:0] mid;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    logic          accept, in_ok, out_ok;
    logic [AW-1:0] a_idx;
    logic [CW-1:0] c_sel;
    logic          ent_live, out_busy;
    logic [OW-1:0] ent_outlet;
    logic [MW-1:0] ent_mid;
    logic [R2-1:0] a_bits, c_bits;
    logic          found;
    logic [MW-1:0] pick;
    logic          map_set, map_clr, tbl_wr, tbl_clr;
    logic [MW-1:0] wr_col;

    // Index decode: which outer matrices the request touches.
    always_comb begin
        accept = req_valid && ctl_q.ready;
        in_ok  = int'(req_inlet)  < NIN_TOT;
        out_ok = int'(req_outlet) < NOUT_TOT;
        a_idx  = AW'(int'(req_inlet) / N_IN);
        if (req_op == OP_CONNECT) begin
            c_sel = CW'(int'(req_outlet) / M_OUT);
        end else begin
            c_sel = CW'(int'(ent_outlet) / M_OUT);
        end
    end

    clos_link_map #(.ROWS(R1), .COLS(R2), .RW(AW), .CW(MW)) u_amap (
        .clk     (clk),
        .rst     (rst),
        .set_en  (map_set),
        .clr_en  (map_clr),
        .row     (a_idx),
        .col     (wr_col),
        .rd_bits (a_bits)
    );

    clos_link_map #(.ROWS(R3), .COLS(R2), .RW(CW), .CW(MW)) u_cmap (
        .clk     (clk),
        .rst     (rst),
        .set_en  (map_set),
        .clr_en  (map_clr),
        .row     (c_sel),
        .col     (wr_col),
        .rd_bits (c_bits)
    );

    clos_mid_pick #(.R2(R2), .MW(MW)) u_pick (
        .a_busy (a_bits),
        .c_busy (c_bits),
        .found  (found),
        .mid    (pick)
    );

    clos_call_table #(
        .NIN(NIN_TOT), .NOUT(NOUT_TOT), .IW(IW), .OW(OW), .MW(MW)
    ) u_calls (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (tbl_wr),
        .clr_en      (tbl_clr),
        .inlet       (req_inlet),
        .outlet      (req_outlet),
        .mid         (pick),
        .ent_live    (ent_live),
        .ent_outlet  (ent_outlet),
        .ent_mid     (ent_mid),
        .outlet_busy (out_busy)
    );

    // Request decision and next response.
    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.ready     = 1'b1;
        ctl_d.rsp_valid = accept;
        ctl_d.status    = ST_OK;
        ctl_d.mid       = '0;
        map_set = 1'b0;
        map_clr = 1'b0;
        tbl_wr  = 1'b0;
        tbl_clr = 1'b0;
        wr_col  = pick;
        if (accept) begin
            if (req_op == OP_CONNECT) begin
                if (!in_ok || !out_ok) begin
                    ctl_d.status = ST_RANGE;
                end else if (ent_live) begin
                    ctl_d.status = ST_IN_BUSY;
                end else if (out_busy) begin
                    ctl_d.status = ST_OUT_BUSY;
                end else if (!found) begin
                    ctl_d.status = ST_BLOCKED;
                end else begin
                    ctl_d.mid = pick;
                    map_set   = 1'b1;
                    tbl_wr    = 1'b1;
                end
            end else begin
                wr_col = ent_mid;
                if (!in_ok) begin
                    ctl_d.status = ST_RANGE;
                end else if (!ent_live) begin
                    ctl_d.status = ST_IN_IDLE;
                end else begin
                    ctl_d.mid = ent_mid;
                    map_clr   = 1'b1;
                    tbl_clr   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{ready: 1'b0, rsp_valid: 1'b0, status: ST_OK, mid: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready  = ctl_q.ready;
    assign rsp_valid  = ctl_q.rsp_valid;
    assign rsp_status = ctl_q.status;
    assign rsp_mid    = ctl_q.mid;

endmodule

// File: rtl/clos_conn_ctrl_chk.sv
module clos_conn_ctrl_chk #(
    parameter int R2 = 3,
    parameter int MW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [2:0]    rsp_status,
    input logic [MW-1:0] rsp_mid
);

    // R1: ready comes up the cycle after reset ends
    p_ready_up_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> req_ready);

    // R2: one response exactly one cycle after each accepted request
    p_rsp_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !rsp_valid);

    // R3: a granted middle index lies inside the middle stage
    p_mid_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 3'd0) |-> (int'(rsp_mid) < R2));

    // R4: error responses carry index 0
    p_err_mid_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 3'd0) |-> (rsp_mid == '0));

    // R9: with the middle stage sized by the rule nothing ever blocks
    p_never_blocked_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_status != 3'd5));

endmodule

bind clos_conn_ctrl clos_conn_ctrl_chk #(.R2(R2), .MW(MW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_mid    (rsp_mid)
);

// File: tb/clos_conn_ctrl_bench.sv
`timescale 1ns/1ps
module clos_conn_ctrl_bench;

    localparam int B_N    = 2;
    localparam int B_M    = 3;
    localparam int B_R1   = 3;
    localparam int B_R3   = 3;
    localparam int B_R2   = B_N + B_M - 1;
    localparam int B_NIN  = B_N * B_R1;
    localparam int B_NOUT = B_M * B_R3;

    typedef struct packed {
        logic       op;
        logic [2:0] inl;
        logic [3:0] outl;
        logic [2:0] st;
        logic [1:0] mid;
    } vec_t;

    // op, inlet, outlet, expected status, expected middle index
    localparam vec_t VEC [16] = '{
        '{1'b0, 3'd0, 4'd0, 3'd0, 2'd0},   // R2 first call
        '{1'b0, 3'd1, 4'd3, 3'd0, 2'd1},   // R3 source link 0 busy
        '{1'b0, 3'd2, 4'd1, 3'd0, 2'd1},   // R3 destination link 0 busy
        '{1'b0, 3'd0, 4'd5, 3'd1, 2'd0},   // R4 inlet busy
        '{1'b0, 3'd3, 4'd0, 3'd2, 2'd0},   // R5 outlet busy
        '{1'b0, 3'd4, 4'd2, 3'd0, 2'd2},   // R3 two destination links busy
        '{1'b1, 3'd1, 4'd0, 3'd0, 2'd1},   // R6 release reports index
        '{1'b1, 3'd1, 4'd0, 3'd3, 2'd0},   // R7 release of idle inlet
        '{1'b0, 3'd1, 4'd4, 3'd0, 2'd1},   // R6 freed links reused
        '{1'b0, 3'd7, 4'd0, 3'd4, 2'd0},   // R8 inlet out of range
        '{1'b0, 3'd5, 4'd9, 3'd4, 2'd0},   // R8 outlet out of range
        '{1'b1, 3'd7, 4'd0, 3'd4, 2'd0},   // R8 release out of range
        '{1'b0, 3'd5, 4'd6, 3'd0, 2'd0},   // R3
        '{1'b1, 3'd0, 4'd0, 3'd0, 2'd0},   // R10 index kept from setup
        '{1'b0, 3'd0, 4'd7, 3'd0, 2'd2},   // R3
        '{1'b0, 3'd3, 4'd8, 3'd0, 2'd3}    // R9 worst case takes last middle
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_op = 1'b0;
    logic [2:0] req_inlet = '0;
    logic [3:0] req_outlet = '0;
    logic       rsp_valid;
    logic [2:0] rsp_status;
    logic [1:0] rsp_mid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // reference state
    bit m_live  [B_NIN];
    int m_out   [B_NIN];
    int m_mid   [B_NIN];
    bit m_obusy [B_NOUT];
    bit m_a     [B_R1][B_R2];
    bit m_c     [B_R3][B_R2];

    always #10 clk = ~clk;

    clos_conn_ctrl #(.N_IN(B_N), .M_OUT(B_M), .R1(B_R1), .R3(B_R3)) u_clos_conn_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_inlet  (req_inlet),
        .req_outlet (req_outlet),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_mid    (rsp_mid)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < B_NIN; i++) begin
            m_live[i] = 1'b0; m_out[i] = 0; m_mid[i] = 0;
        end
        for (int o = 0; o < B_NOUT; o++) m_obusy[o] = 1'b0;
        for (int r = 0; r < B_R1; r++) for (int k = 0; k < B_R2; k++) m_a[r][k] = 1'b0;
        for (int r = 0; r < B_R3; r++) for (int k = 0; k < B_R2; k++) m_c[r][k] = 1'b0;
    endtask

    task automatic model(input logic op, input int inl, input int outl,
                         output int st, output int mid, output bit idle_pair);
        st = 0; mid = 0; idle_pair = 1'b0;
        if (op == 1'b0) begin
            if (inl >= B_NIN || outl >= B_NOUT) st = 4;
            else if (m_live[inl]) st = 1;
            else if (m_obusy[outl]) st = 2;
            else begin
                idle_pair = 1'b1;
                st = 5;
                for (int k = B_R2 - 1; k >= 0; k--) begin
                    if (!m_a[inl / B_N][k] && !m_c[outl / B_M][k]) begin
                        st = 0; mid = k;
                    end
                end
                if (st == 0) begin
                    m_live[inl] = 1'b1; m_out[inl] = outl; m_mid[inl] = mid;
                    m_obusy[outl] = 1'b1;
                    m_a[inl / B_N][mid] = 1'b1;
                    m_c[outl / B_M][mid] = 1'b1;
                end
            end
        end else begin
            if (inl >= B_NIN) st = 4;
            else if (!m_live[inl]) st = 3;
            else begin
                mid = m_mid[inl];
                m_live[inl] = 1'b0;
                m_obusy[m_out[inl]] = 1'b0;
                m_a[inl / B_N][mid] = 1'b0;
                m_c[m_out[inl] / B_M][mid] = 1'b0;
            end
        end
    endtask

    task automatic issue(input logic op, input int inl, input int outl,
                         output int vld, output int st, output int mid);
        @(negedge clk);
        req_valid  = 1'b1;
        req_op     = op;
        req_inlet  = 3'(inl);
        req_outlet = 4'(outl);
        @(negedge clk);
        req_valid = 1'b0;
        vld = int'(rsp_valid);
        st  = int'(rsp_status);
        mid = int'(rsp_mid);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int vld, st, mid, est, emid;
        bit idle;
        model_clear();

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 ready in reset", int'(req_ready), 0);
        check("R1 rsp_valid in reset", int'(rsp_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready after reset", int'(req_ready), 1);
        check("R1 no response after reset", int'(rsp_valid), 0);

        // vector table
        for (int v = 0; v < 16; v++) begin
            issue(VEC[v].op, int'(VEC[v].inl), int'(VEC[v].outl), vld, st, mid);
            model(VEC[v].op, int'(VEC[v].inl), int'(VEC[v].outl), est, emid, idle);
            check($sformatf("R2 vector %0d valid", v), vld, 1);
            check($sformatf("R2-R10 vector %0d status", v), st, int'(VEC[v].st));
            check($sformatf("R3 vector %0d mid", v), mid, int'(VEC[v].mid));
        end

        // R1: reset in the middle of traffic clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 ready during second reset", int'(req_ready), 0);
        check("R1 rsp_valid during second reset", int'(rsp_valid), 0);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        issue(1'b1, 2, 0, vld, st, mid);
        check("R1 release after reset sees idle inlet", st, 3);

        // R2/R3: back-to-back requests see each other's link updates
        @(negedge clk);
        req_valid = 1'b1; req_op = 1'b0; req_inlet = 3'd0; req_outlet = 4'd0;
        @(negedge clk);
        check("R2 back-to-back first valid", int'(rsp_valid), 1);
        check("R3 back-to-back first mid", int'(rsp_mid), 0);
        req_inlet = 3'd1; req_outlet = 4'd1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 back-to-back second valid", int'(rsp_valid), 1);
        check("R3 back-to-back second mid", int'(rsp_mid), 1);
        @(negedge clk);
        check("R2 no response without request", int'(rsp_valid), 0);
        model(1'b0, 0, 0, est, emid, idle);
        model(1'b0, 1, 1, est, emid, idle);

        // R9: random traffic on the minimum-size middle stage
        for (int t = 0; t < 3000; t++) begin
            logic op;
            int inl, outl;
            op   = ($urandom_range(0, 2) == 0) ? 1'b1 : 1'b0;
            inl  = $urandom_range(0, B_NIN);
            outl = $urandom_range(0, B_NOUT);
            issue(op, inl, outl, vld, st, mid);
            model(op, inl, outl, est, emid, idle);
            check("R2 random valid", vld, 1);
            if (idle) check("R9 idle pair connect status", st, 0);
            else      check("R4-R8 random status", st, est);
            check("R3 R6 random mid", mid, emid);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule